// File: doc/BRIEF.md
# Timed Access Write Protection Unit

This unit keeps a set of protected register bits from being changed by a stray bus write. It watches a single unlock address on the local register bus. Software must write a two-byte key to that address in the right order, with the second byte close behind the first. Only then does the unit raise a short write-enable window. The surrounding register file uses that enable to gate writes to its protected fields. Once the window has run out, the enable drops, and a fresh key is needed before protected bits can change again.

The unit has two state machines, each with its own counter. The key sequencer has two states. `KS_IDLE` moves to `KS_ARMED` when the first key byte (AAh) is written (transition *arm*). `KS_ARMED` moves back to `KS_ARMED` on a further AAh write (transition *rearm*). It returns to `KS_IDLE` on any other unlock write (transition *abort*, which includes the accepted second byte) or when its gap counter runs out (transition *lapse*). The window timer also has two states. `WS_SHUT` moves to `WS_OPEN` when the sequencer accepts the second key byte (transition *open*). `WS_OPEN` reloads itself on another accepted key (transition *reload*) and returns to `WS_SHUT` after its last cycle (transition *expire*). A small decoder turns each bus write into one of three key events.

The unlock register cannot be read back and stores nothing. Its idle content counts as all ones, which matches neither key byte. With the default parameters, the unlock address is C7h, the key bytes are AAh then 55h, the key gap is 3 cycles and the window is 3 cycles.

Top module: `ta_guard`

## Requirements
- R1: During and right after reset, `prot_we` is 0 and `ta_status` is 2'b00.
- R2: A write of AAh to the unlock address C7h arms the sequencer. `ta_status[0]` is 1 in the 3 cycles after the write edge. It drops after the third edge if no other unlock write comes.
- R3: A write of 55h to C7h while armed opens the window. `prot_we` and `ta_status[1]` are 1 for exactly 3 cycles after that write edge, then 0.
- R4: A write of 55h that finds the sequencer unarmed does not open the window. This covers a 55h with no AAh before it, and a 55h that comes 4 or more cycles after the AAh.
- R5: While armed, any write to C7h other than AAh disarms the sequencer on that edge. This includes the accepted 55h.
- R6: Cycles with `wr_en` low and writes to any address other than C7h have no effect on either state machine.
- R7: An AAh write while the window is open arms the sequencer, but it does not extend the current window.
- R8: A complete AAh then 55h sequence while the window is open restarts the window, so it runs a full 3 cycles from the new 55h write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| prot_we | output | 1 | Protected-write enable for the register file |
| ta_status | output | 2 | Bit 0: key armed; bit 1: window open |

## Verification
The hardest case to reach from the ports is a key sequence that overlaps an open window. Here the sequencer and the timer hold live counts at the same time. The rearm must leave the window's end unchanged, and the following 55h must reload the window. The bench gets there by opening a window and then placing a new AAh at each possible window offset. It tracks the window offset it expects cycle by cycle. It also sweeps the AAh-to-55h gap across the limit, every second data byte, and every address.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_state_e;

    typedef enum logic {
        WS_SHUT,
        WS_OPEN
    } win_state_e;

    // One decoded bus cycle at the unlock address
    typedef struct packed {
        logic first;   // first key byte written
        logic second;  // second key byte written
        logic other;   // any other byte written
    } key_evt_t;

endpackage

// File: rtl/ta_key_decode.sv
module ta_key_decode
    import ta_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output key_evt_t          evt
);

    logic hit;

    always_comb begin
        hit        = wr_en && (wr_addr == UNLOCK_ADDR);
        evt.first  = hit && (wr_data == KEY_FIRST);
        evt.second = hit && (wr_data == KEY_SECOND);
        evt.other  = hit && (wr_data != KEY_FIRST) && (wr_data != KEY_SECOND);
    end

endmodule

// File: rtl/ta_key_seq.sv
module ta_key_seq
    import ta_guard_pkg::*;
#(
    parameter int KEY_GAP = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  key_evt_t evt,
    output logic     armed,
    output logic     key_ok
);

    localparam int GW = (KEY_GAP < 2) ? 1 : $clog2(KEY_GAP);
    localparam logic [GW-1:0] GAP_LAST = GW'(KEY_GAP - 1);

    key_state_e state_q, state_d;
    logic [GW-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            KS_IDLE: begin
                if (evt.first) begin           // arm
                    state_d = KS_ARMED;
                    cnt_d   = '0;
                end
            end
            KS_ARMED: begin
                if (evt.first) begin           // rearm
                    state_d = KS_ARMED;
                    cnt_d   = '0;
                end else if (evt.second || evt.other) begin  // abort
                    state_d = KS_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == GAP_LAST) begin        // lapse
                    state_d = KS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = KS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        armed  = (state_q == KS_ARMED);
        key_ok = armed && evt.second;
    end

endmodule

// File: rtl/ta_win_timer.sv
module ta_win_timer
    import ta_guard_pkg::*;
#(
    parameter int WIN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic open
);

    localparam int WW = (WIN_LEN < 2) ? 1 : $clog2(WIN_LEN);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

    win_state_e state_q, state_d;
    logic [WW-1:0] cnt_q, cnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_SHUT: begin
                if (load) begin                // open
                    state_d = WS_OPEN;
                    cnt_d   = '0;
                end
            end
            WS_OPEN: begin
                if (load) begin                // reload
                    state_d = WS_OPEN;
                    cnt_d   = '0;
                end else if (cnt_q == WIN_LAST) begin  // expire
                    state_d = WS_SHUT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = WS_SHUT;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_SHUT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        open = (state_q == WS_OPEN);
    end

endmodule

// File: rtl/ta_guard.sv
module ta_guard
    import ta_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
    parameter int KEY_GAP = 3,
    parameter int WIN_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prot_we,
    output logic [1:0]        ta_status
);

    key_evt_t evt;
    logic     armed;
    logic     key_ok;
    logic     win_open;

    ta_key_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .UNLOCK_ADDR (UNLOCK_ADDR),
        .KEY_FIRST   (KEY_FIRST),
        .KEY_SECOND  (KEY_SECOND)
    ) i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt     (evt)
    );

    ta_key_seq #(
        .KEY_GAP (KEY_GAP)
    ) i_key_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .armed  (armed),
        .key_ok (key_ok)
    );

    ta_win_timer #(
        .WIN_LEN (WIN_LEN)
    ) i_win_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (key_ok),
        .open  (win_open)
    );

    always_comb begin
        prot_we   = win_open;
        ta_status = {win_open, armed};
    end

endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'hC7,
    parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
    parameter int KEY_GAP = 3,
    parameter int WIN_LEN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prot_we,
    input logic [1:0]        ta_status
);

    localparam int CW = $clog2(KEY_GAP + WIN_LEN + 2);

    logic unl_wr;
    logic aa_wr;
    logic acc_wr;
    logic [CW-1:0] since_aa;
    logic [CW-1:0] since_acc;

    always_comb begin
        unl_wr = wr_en && (wr_addr == UNLOCK_ADDR);
        aa_wr  = unl_wr && (wr_data == KEY_FIRST);
        acc_wr = unl_wr && (wr_data == KEY_SECOND) && ta_status[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_aa  <= CW'(KEY_GAP);
            since_acc <= CW'(WIN_LEN);
        end else begin
            if (aa_wr)
                since_aa <= '0;
            else if (since_aa < CW'(KEY_GAP))
                since_aa <= since_aa + 1'b1;
            if (acc_wr)
                since_acc <= '0;
            else if (since_acc < CW'(WIN_LEN))
                since_acc <= since_acc + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!prot_we && ta_status == 2'b00)); // R1

    AST_ARM_LAPSES: assert property (@(posedge clk) disable iff (!rst_n)
        ta_status[0] |-> (since_aa < CW'(KEY_GAP))); // R2

    AST_WIN_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |-> (since_acc < CW'(WIN_LEN))); // R3

    AST_WIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (since_acc < CW'(WIN_LEN)) |-> prot_we); // R8

    AST_NO_OPEN_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (unl_wr && wr_data == KEY_SECOND && !ta_status[0]) |=> !$rose(prot_we)); // R4

    AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_status[0] && unl_wr && wr_data != KEY_FIRST) |=> !ta_status[0]); // R5

    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ta_status[1] == prot_we); // R3

endmodule

bind ta_guard ta_guard_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .UNLOCK_ADDR (UNLOCK_ADDR),
    .KEY_FIRST   (KEY_FIRST),
    .KEY_SECOND  (KEY_SECOND),
    .KEY_GAP     (KEY_GAP),
    .WIN_LEN     (WIN_LEN)
) i_ta_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .prot_we   (prot_we),
    .ta_status (ta_status)
);

// File: tb/test_ta_guard.sv
module test_ta_guard;

    localparam logic [7:0] UA = 8'hC7;
    localparam logic [7:0] K1 = 8'hAA;
    localparam logic [7:0] K2 = 8'h55;
    localparam int GAP = 3;
    localparam int WIN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       prot_we;
    logic [1:0] ta_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ta_guard i_ta_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .prot_we   (prot_we),
        .ta_status (ta_status)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Drive one bus cycle; returns at the next falling edge, after the rising edge that consumed it
    task automatic tick(input logic w, input logic [7:0] a, input logic [7:0] d);
        wr_en   = w;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 8'h00);
    endtask

    task automatic chk(input string rq, input logic exp_open, input logic exp_armed);
        checks = checks + 1;
        if (prot_we !== exp_open || ta_status !== {exp_open, exp_armed}) begin
            errors = errors + 1;
            $display("FAIL %s: actual we=%b st=%b, expected we=%b st=%b",
                     rq, prot_we, ta_status, exp_open, {exp_open, exp_armed});
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0);

        // R2 R3 R4: gap sweep from AAh to 55h
        for (int g = 1; g <= 6; g++) begin
            tick(1'b1, UA, K1);
            chk("R2 armed after AAh", 1'b0, 1'b1);
            for (int j = 1; j < g; j++) begin
                tick(1'b0, 8'h00, 8'h00);
                chk("R2 armed during gap", 1'b0, j < GAP);
            end
            tick(1'b1, UA, K2);
            for (int k = 0; k <= WIN; k++)
                begin
                    chk((g <= GAP) ? "R3 window after key" : "R4 late 55h", (g <= GAP) && (k < WIN), 1'b0);
                    tick(1'b0, 8'h00, 8'h00);
                end
            idle(2);
        end

        // R4: 55h without AAh
        tick(1'b1, UA, K2);
        chk("R4 lone 55h", 1'b0, 1'b0);
        idle(1);
        chk("R4 lone 55h later", 1'b0, 1'b0);

        // R5: every second byte after AAh
        for (int d = 0; d < 256; d++) begin
            tick(1'b1, UA, K1);
            tick(1'b1, UA, 8'(d));
            chk("R5 second byte sweep", 8'(d) == K2, 8'(d) == K1);
            idle(WIN + GAP);
            chk("R5 settles", 1'b0, 1'b0);
        end

        // R6: 55h at other addresses and with strobe low
        for (int a = 0; a < 256; a++) begin
            if (8'(a) == UA) continue;
            tick(1'b1, UA, K1);
            tick(1'b1, 8'(a), K2);
            chk("R6 foreign address", 1'b0, 1'b1);
            tick(1'b0, UA, K2);
            chk("R6 strobe low", 1'b0, 1'b1);
            tick(1'b1, UA, K2);
            chk("R6 key still valid", 1'b1, 1'b0);
            idle(WIN + 1);
        end

        // R7 R8: AAh at each offset of an open window, then 55h
        for (int k = 0; k < WIN; k++) begin
            int off;
            tick(1'b1, UA, K1);
            tick(1'b1, UA, K2);
            off = 0;
            for (int i = 0; i < k; i++) begin
                tick(1'b0, 8'h00, 8'h00);
                off++;
            end
            tick(1'b1, UA, K1);
            off++;
            chk("R7 rearm in window", off < WIN, 1'b1);
            for (int i = 0; i < 3; i++) begin
                tick(1'b0, 8'h00, 8'h00);
                off++;
                chk("R7 window not extended", off < WIN, i < GAP - 1);
            end
            idle(3);
            // R8: full key while open
            tick(1'b1, UA, K1);
            tick(1'b1, UA, K2);
            idle(k);
            tick(1'b1, UA, K1);
            tick(1'b1, UA, K2);
            for (int i = 0; i <= WIN; i++) begin
                chk("R8 reload full length", i < WIN, 1'b0);
                tick(1'b0, 8'h00, 8'h00);
            end
            idle(2);
        end

        // R1: reset in the middle of an open window
        tick(1'b1, UA, K1);
        tick(1'b1, UA, K2);
        tick(1'b1, UA, K1);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid window", 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after mid reset", 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule